// File: doc/BRIEF.md
# Programmable Interval Timer with Expiry Pulse

This block is a down-counting interval timer for a processor sequencer. Software drives a single write strobe with a two-bit register select and a data word. It can load the live count, load the reload period, or write a mode word in which one bit starts and stops the timer. The live count is always visible on an output port, so it can be read back at any time.

While the timer runs, the count drops by one on every clock. When the count is found at zero, three things happen:
- A one-cycle interrupt request is raised in that same cycle.
- The next cycle reloads the count from the period register.
- An expiry pin goes high for a fixed number of cycles (four by default).

The gap between interrupts is therefore the period plus one. The usual sequence is to load the count and the period with the timer stopped, then set the enable bit.

The control is split across two small state machines:
- **Run machine** (`RUN_OFF`, `RUN_ON`). `RUN_OFF` moves to `RUN_ON` on a mode write with the enable bit set. `RUN_ON` returns to `RUN_OFF` on a mode write with the enable bit clear. Any other mode write leaves the state unchanged.
- **Pin machine** (`PIN_IDLE`, `PIN_HIGH`).
  - `PIN_IDLE` moves to `PIN_HIGH` on a zero hit.
  - `PIN_HIGH` re-arms its cycle counter on a further zero hit.
  - `PIN_HIGH` returns to `PIN_IDLE` when the last pulse cycle has been spent.
  - Either state drops to `PIN_IDLE` when the run machine is off.

Top module: `interval_timer`

## Requirements
- R1: A synchronous active-high reset clears the count, the period, the enable bit, `irq_o` and `expiry_o`.
- R2: While enabled and not at zero, the count decreases by exactly one per clock.
- R3: `irq_o` is high for exactly the cycles in which the timer is enabled and the count is zero.
- R4: The cycle after a zero hit, the count equals the period register, unless software writes the count in the zero-hit cycle.
- R5: With count and period both loaded with P before enabling, successive interrupts are P+1 cycles apart.
- R6: After a zero hit, `expiry_o` is high for the next PULSE_CYCLES cycles (4 by default), as long as the timer stays enabled.
- R7: A zero hit while the pin is already high restarts the pulse at its full length.
- R8: While disabled, the count holds its value and `irq_o` and `expiry_o` are low. Disabling during a pulse drops the pin at once.
- R9: Writing select 2 (mode) sets the enable from data bit 5 only. All other data bits are ignored.
- R10: Select 0 writes the count. This write wins over both the decrement and the reload in the same cycle. `count_o` shows the count at all times.
- R11: Select 1 writes the period without disturbing the count. Select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 count, 1 period, 2 mode, 3 none |
| wr_data | input | W | Write data; bit EN_BIT is the enable in a mode write |
| count_o | output | W | Live count (read-back) |
| irq_o | output | 1 | One-cycle interrupt request on a zero hit |
| expiry_o | output | 1 | Expiry pin, high for PULSE_CYCLES cycles after a zero hit |

## Verification
The bench builds the timer with W = 8 and the default PULSE_CYCLES = 4, so every count and period value fits in a byte.

It sweeps the period from 0 to 20 and measures interrupt spacing against P+1. The short periods (0 to 2) produce zero hits faster than the pulse length, which exercises the pulse restart.

A cycle-accurate arithmetic model checks the count, the interrupt and the pin on every cycle. This covers:
- mode writes that leave bit 5 clear;
- count writes that land on a zero hit;
- disabling in mid-pulse;
- a reset in the middle of a run.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_state_e;

    typedef enum logic {
        PIN_IDLE = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] period_o
);
    logic [W-1:0] period_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
        end else if (wr_en && wr_sel == SEL_PERIOD) begin
            period_q <= wr_data;
        end
    end

    assign period_o = period_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_wr,
    input  logic         mode_bit,
    input  logic         count_wr,
    input  logic [W-1:0] count_wdata,
    input  logic [W-1:0] period,
    output logic [W-1:0] count_o,
    output logic         run_o,
    output logic         zero_hit_o
);
    run_state_e   run_q, run_d;
    logic [W-1:0] count_q, count_d;
    logic         zero_hit;

    // Run machine: state register
    always_ff @(posedge clk) begin
        if (rst) run_q <= RUN_OFF;
        else     run_q <= run_d;
    end

    // Run machine: transitions
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_OFF: if (mode_wr && mode_bit)  run_d = RUN_ON;
            RUN_ON:  if (mode_wr && !mode_bit) run_d = RUN_OFF;
        endcase
    end

    // Outputs and count datapath
    always_comb begin
        zero_hit = (run_q == RUN_ON) && (count_q == '0);
        count_d  = count_q;
        if (count_wr)               count_d = count_wdata;
        else if (zero_hit)          count_d = period;
        else if (run_q == RUN_ON)   count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count_o    = count_q;
    assign run_o      = (run_q == RUN_ON);
    assign zero_hit_o = zero_hit;
endmodule

// File: rtl/tmr_pulse.sv
module tmr_pulse
    import timer_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic trigger,
    output logic pin_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);

    pin_state_e    st_q, st_d;
    logic [CW-1:0] left_q, left_d;

    // Pin machine: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PIN_IDLE;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    // Pin machine: transitions
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        if (!enable) begin
            st_d   = PIN_IDLE;
            left_d = '0;
        end else begin
            unique case (st_q)
                PIN_IDLE: begin
                    if (trigger) begin
                        st_d   = PIN_HIGH;
                        left_d = CW'(PULSE_CYCLES);
                    end
                end
                PIN_HIGH: begin
                    if (trigger) begin
                        left_d = CW'(PULSE_CYCLES);
                    end else if (left_q == CW'(1)) begin
                        st_d   = PIN_IDLE;
                        left_d = '0;
                    end else begin
                        left_d = left_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Pin machine: outputs
    always_comb begin
        pin_o = (st_q == PIN_HIGH) && enable;
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int W            = 32,
    parameter int EN_BIT       = 5,
    parameter int PULSE_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic         irq_o,
    output logic         expiry_o
);
    logic [W-1:0] period_q;
    logic         run_on;
    logic         zero_hit;
    logic         mode_wr, count_wr;

    assign mode_wr  = wr_en && (wr_sel == SEL_MODE);
    assign count_wr = wr_en && (wr_sel == SEL_COUNT);

    tmr_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .period_o (period_q)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (mode_wr),
        .mode_bit    (wr_data[EN_BIT]),
        .count_wr    (count_wr),
        .count_wdata (wr_data),
        .period      (period_q),
        .count_o     (count_o),
        .run_o       (run_on),
        .zero_hit_o  (zero_hit)
    );

    tmr_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .enable  (run_on),
        .trigger (zero_hit),
        .pin_o   (expiry_o)
    );

    assign irq_o = zero_hit;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int W      = 32,
    parameter int EN_BIT = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] count_o,
    input logic         irq_o,
    input logic         expiry_o,
    input logic [W-1:0] period,
    input logic         run
);
    logic cwr, stop_wr;
    assign cwr     = wr_en && (wr_sel == 2'd0);
    assign stop_wr = wr_en && (wr_sel == 2'd2) && !wr_data[EN_BIT];

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        run && count_o != '0 && !cwr |=> count_o == $past(count_o) - 1'b1); // R2

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        irq_o && !cwr |=> count_o == $past(period)); // R4

    AST_PIN_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq_o && !stop_wr |=> expiry_o); // R6

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !run && !cwr |=> $stable(count_o)); // R8

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !run |-> !irq_o && !expiry_o); // R8

    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        cwr |=> count_o == $past(wr_data)); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> count_o == '0 && !irq_o && !expiry_o); // R1
endmodule

bind interval_timer interval_timer_chk #(.W(W), .EN_BIT(EN_BIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .count_o  (count_o),
    .irq_o    (irq_o),
    .expiry_o (expiry_o),
    .period   (period_q),
    .run      (run_on)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int PULSE      = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd3;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count_o;
    logic         irq_o, expiry_o;

    int ntest = 0;
    int nfail = 0;

    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_per = '0;
    bit           m_en  = 1'b0;
    int           m_pl  = 0;
    bit           seen_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer #(.W(W), .PULSE_CYCLES(PULSE)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_o(count_o), .irq_o(irq_o), .expiry_o(expiry_o)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // One clock: drive, check outputs against the model, advance the model.
    task automatic cyc(input bit we, input logic [1:0] sel, input logic [W-1:0] d, input string r);
        bit zero;
        wr_en = we; wr_sel = sel; wr_data = d;
        #1;
        zero = m_en && (m_cnt == 0);
        chk(r, count_o, m_cnt);
        chk("R3 irq", irq_o, zero);
        chk("R6 pin", expiry_o, m_en && m_pl > 0);
        seen_irq = irq_o;
        @(posedge clk);
        if (!m_en)     m_pl = 0;
        else if (zero) m_pl = PULSE;
        else if (m_pl > 0) m_pl--;
        if (we && sel == 2'd0)  m_cnt = d;
        else if (zero)          m_cnt = m_per;
        else if (m_en)          m_cnt = m_cnt - 1'b1;
        if (we && sel == 2'd1)  m_per = d;
        if (we && sel == 2'd2)  m_en  = d[5];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input string r);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd3, '0, r);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = '0; m_per = '0; m_en = 1'b0; m_pl = 0;
        chk("R1 count", count_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 pin", expiry_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R8 / R11: loads while disabled, count holds
        cyc(1'b1, 2'd0, 8'd5, "R10 count write");
        cyc(1'b1, 2'd1, 8'd3, "R11 period write");
        idle(4, "R8 hold");
        cyc(1'b1, 2'd3, 8'hFF, "R11 sel3 ignored");
        idle(2, "R11 after sel3");
        // R9: mode write without bit 5 does not start the timer
        cyc(1'b1, 2'd2, 8'hDF, "R9 other bits");
        idle(4, "R9 still off");
        cyc(1'b1, 2'd2, 8'h20, "R9 enable");
        idle(30, "R2 R4 run");

        // R7: zero hits faster than pulse length
        cyc(1'b1, 2'd1, 8'd1, "R11 period change");
        idle(20, "R7 retrigger");
        cyc(1'b1, 2'd1, 8'd0, "R11 period zero");
        idle(10, "R7 period0");

        // R10: count write landing on zero hit
        cyc(1'b1, 2'd1, 8'd6, "R11 period");
        while (!(m_en && m_cnt == 0)) cyc(1'b0, 2'd3, '0, "R2 wait zero");
        cyc(1'b1, 2'd0, 8'd9, "R10 write on zero");
        idle(3, "R10 after write");
        cyc(1'b1, 2'd0, 8'd2, "R10 write mid-count");
        idle(4, "R10 run");

        // R8: disable during pulse
        while (!(m_en && m_pl > 0)) cyc(1'b0, 2'd3, '0, "R6 wait pulse");
        cyc(1'b1, 2'd2, 8'h00, "R8 disable");
        idle(5, "R8 off quiet");

        // R5 sweep
        for (int p = 0; p <= 20; p++) begin
            int cnum = 0;
            int prev = -1;
            int nirq = 0;
            cyc(1'b1, 2'd2, 8'h00, "R8 stop");
            cyc(1'b1, 2'd0, 8'(p), "R10 load");
            cyc(1'b1, 2'd1, 8'(p), "R11 load");
            cyc(1'b1, 2'd2, 8'h20, "R9 start");
            while (nirq < 4 && cnum < 200) begin
                cyc(1'b0, 2'd3, '0, "R2 sweep");
                if (seen_irq) begin
                    if (prev >= 0) chk("R5 interval", cnum - prev, p + 1);
                    prev = cnum;
                    nirq++;
                end
                cnum++;
            end
            chk("R5 irq count", nirq, 4);
        end

        // R1: reset mid-run
        do_reset();
        idle(3, "R1 after reset");

        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule